// File: doc/BRIEF.md
# Two-stage fast-settling sinc decimator

This block turns the single-bit output stream of a sigma-delta modulator into one signed word per 128 modulator samples. A short third-order integrator-comb front end decimates by 4, then a 32-slot integrate-and-dump stage adds up its outputs. The combined response spans only 134 modulator samples. A conversion therefore settles in a little over one output period, where a single third-order sinc of the same ratio would need 382 samples.

A one-cycle `start` pulse begins a conversion and clears the whole filter. The modulator bit is taken only in cycles where `smp_en` is high. The first result is flagged 134 accepted samples after `start`, and each later one 128 samples after the one before. A small controller with two states runs the block. SETTLE discards the first front-end outputs, whose windows begin before the conversion. STREAM passes every front-end output into the dump stage. SETTLE moves to STREAM once those two outputs have been discarded. Reset or `start` always returns the controller to SETTLE. The result is left unnormalized: full scale is ±2048.

Top module: `sinc_decim_2stage`

## Requirements
- R1: Bit value 1 counts as +1 and bit value 0 counts as −1. A conversion fed only ones gives +2048, and one fed only zeros gives −2048.
- R2: After `start` or reset, `valid` is first high in the clock cycle after the edge that takes the 134th accepted sample. It stays low before that.
- R3: After the first result, `valid` is high once every 128 accepted samples. On the k-th strobe the sample count since start is 134 + 128·(k−1).
- R4: Each result equals the sum of h[j]·x[n−j] for j from 0 to 133. Here x[n] is the most recent accepted sample (±1), samples from before the start count as 0, and h is three 4-tap boxcars convolved with 32 unit taps spaced 4 apart.
- R5: `valid` is high for exactly one clock. `result` keeps its value between strobes.
- R6: `start` clears all filter state, and `result` reads 0 in the following cycle. A sample presented together with `start` is dropped, and no strobe follows the `start` cycle.
- R7: Cycles with `smp_en` low change neither `result` nor the filter state, and `valid` stays low in them.
- R8: Reset leaves `valid` low and `result` at 0, and starts a conversion just as `start` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Accept `mod_bit` this cycle |
| mod_bit | input | 1 | Modulator output bit |
| start | input | 1 | Begin a new conversion; overrides `smp_en` |
| result | output | 13 | Signed unnormalized filter sum |
| valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
A new conversion request can arrive in the same cycle as an accepted sample. The case that matters most is the one where that sample would have completed a result. The bench provokes this by raising `start` together with `smp_en` in place of the 134th sample. It then expects no strobe, `result` at 0, and the next conversion's first result exactly as if the dropped sample had never existed. The same check runs with constant inputs and with random bits at irregular enable spacing.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;
    typedef enum logic [0:0] {
        ST_SETTLE = 1'b0,
        ST_STREAM = 1'b1
    } dec_state_e;
endpackage

// File: rtl/cic_front.sv
module cic_front #(
    parameter int R1    = 4,
    parameter int ORDER = 3,
    parameter int W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                dec,
    input  logic                in_bit,
    output logic signed [W-1:0] y
);
    localparam int GAIN = R1 ** ORDER;

    logic signed [W-1:0] x_val;
    logic signed [W-1:0] chain [ORDER+1];
    logic signed [W-1:0] cmb   [ORDER+1];

    assign x_val    = in_bit ? W'(1) : -W'(1);
    assign chain[0] = x_val;
    assign cmb[0]   = chain[ORDER];
    assign y        = cmb[ORDER];

    for (genvar g = 0; g < ORDER; g++) begin : g_sec
        logic signed [W-1:0] integ_q;
        logic signed [W-1:0] dly_q;

        assign chain[g+1] = integ_q + chain[g];
        assign cmb[g+1]   = cmb[g] - dly_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                integ_q <= '0;
                dly_q   <= '0;
            end else if (clr) begin
                integ_q <= '0;
                dly_q   <= '0;
            end else if (en) begin
                integ_q <= chain[g+1];
                if (dec) begin
                    dly_q <= cmb[g];
                end
            end
        end
    end

    // R4: each decimated front-end word is a 10-tap window sum, bounded by the gain
    a_r4_front_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dec && !clr) |-> (int'(y) <= GAIN && int'(y) >= -GAIN));
endmodule

// File: rtl/boxcar_dump.sv
module boxcar_dump #(
    parameter int W_IN  = 8,
    parameter int W_OUT = 13,
    parameter int LIMIT = 2048
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic                    first,
    input  logic                    last,
    input  logic signed [W_IN-1:0]  y,
    output logic signed [W_OUT-1:0] result,
    output logic                    valid
);
    logic signed [W_OUT-1:0] acc_q;
    logic signed [W_OUT-1:0] sum;

    assign sum = (first ? '0 : acc_q) + W_OUT'(y);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else if (clr) begin
            acc_q  <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= take && last;
            if (take) begin
                acc_q <= sum;
                if (last) begin
                    result <= sum;
                end
            end
        end
    end

    // R1: a finished sum never exceeds full scale
    a_r1_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(result) <= LIMIT && int'(result) >= -LIMIT));
endmodule

// File: rtl/sinc_decim_2stage.sv
module sinc_decim_2stage
    import sinc_dec_pkg::*;
#(
    parameter int R1    = 4,
    parameter int R2    = 32,
    parameter int ORDER = 3,
    localparam int W_FRONT = ORDER * $clog2(R1) + 2,
    localparam int W_RES   = W_FRONT + $clog2(R2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    mod_bit,
    input  logic                    start,
    output logic signed [W_RES-1:0] result,
    output logic                    valid
);
    localparam int FRONT_LEN = ORDER * (R1 - 1) + 1;
    localparam int DEC_PH    = (FRONT_LEN - 1) % R1;
    localparam int WARM_N    = (FRONT_LEN - 1) / R1;
    localparam int PW        = (R1 > 1) ? $clog2(R1) : 1;
    localparam int WCW       = $clog2(WARM_N + 2);
    localparam int SW        = (R2 > 1) ? $clog2(R2) : 1;
    localparam int LIMIT     = (R1 ** ORDER) * R2;
    localparam dec_state_e INIT_ST = (WARM_N == 0) ? ST_STREAM : ST_SETTLE;

    dec_state_e state_q, state_d;
    logic [PW-1:0]  phase_q, phase_d;
    logic [WCW-1:0] warm_q, warm_d;
    logic [SW-1:0]  slot_q, slot_d;

    logic take_smp, dec, feed, first, last;
    logic signed [W_FRONT-1:0] front_y;

    assign take_smp = smp_en && !start;
    assign dec      = take_smp && (phase_q == PW'(DEC_PH));

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_ST;
            phase_q <= '0;
            warm_q  <= '0;
            slot_q  <= '0;
        end else if (start) begin
            state_q <= INIT_ST;
            phase_q <= '0;
            warm_q  <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            warm_q  <= warm_d;
            slot_q  <= slot_d;
        end
    end

    // Next state and controls
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        warm_d  = warm_q;
        slot_d  = slot_q;
        feed    = 1'b0;
        first   = 1'b0;
        last    = 1'b0;
        if (take_smp) begin
            phase_d = (phase_q == PW'(R1 - 1)) ? '0 : phase_q + 1'b1;
        end
        if (dec) begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (warm_q == WCW'(WARM_N - 1)) begin
                        state_d = ST_STREAM;
                        warm_d  = '0;
                    end else begin
                        warm_d = warm_q + 1'b1;
                    end
                end
                ST_STREAM: begin
                    feed   = 1'b1;
                    first  = (slot_q == '0);
                    last   = (slot_q == SW'(R2 - 1));
                    slot_d = last ? '0 : slot_q + 1'b1;
                end
            endcase
        end
    end

    cic_front #(
        .R1    (R1),
        .ORDER (ORDER),
        .W     (W_FRONT)
    ) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .en     (take_smp),
        .dec    (dec),
        .in_bit (mod_bit),
        .y      (front_y)
    );

    boxcar_dump #(
        .W_IN  (W_FRONT),
        .W_OUT (W_RES),
        .LIMIT (LIMIT)
    ) u_dump (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .take   (feed),
        .first  (first),
        .last   (last),
        .y      (front_y),
        .result (result),
        .valid  (valid)
    );

    // R5: strobe lasts one clock
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R6: start wipes the result and suppresses the strobe
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!valid && result == '0));
    // R7: idle cycles leave the output untouched
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !start) |=> ($stable(result) && !valid));
    // R2: no result while the front end is still settling
    a_r2_quiet_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> !valid);
endmodule

// File: tb/sim_sinc_decim_2stage.sv
`timescale 1ns/1ps
module sim_sinc_decim_2stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic mod_bit = 1'b0;
    logic start = 1'b0;
    logic signed [12:0] result;
    logic valid;

    int h [134];
    int xs [4096];
    int nsamp = 0;
    int total = 0;
    int bad = 0;
    int last_res = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sinc_decim_2stage u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .mod_bit(mod_bit),
        .start(start), .result(result), .valid(valid)
    );

    function automatic void build_h();
        int a [10];
        int t [10];
        for (int i = 0; i < 10; i++) a[i] = (i < 4) ? 1 : 0;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 10; i++) begin
                t[i] = 0;
                for (int k = 0; k < 4; k++) if (i - k >= 0) t[i] += a[i - k];
            end
            a = t;
        end
        for (int i = 0; i < 134; i++) h[i] = 0;
        for (int m = 0; m < 32; m++)
            for (int i = 0; i < 10; i++) h[4 * m + i] += a[i];
    endfunction

    function automatic int conv_at(int n);
        int s = 0;
        for (int j = 0; j < 134; j++) if (n - j >= 0) s += h[j] * xs[n - j];
        return s;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(bit b);
        bit exp_v;
        int e;
        smp_en = 1'b1;
        mod_bit = b;
        @(posedge clk);
        @(negedge clk);
        smp_en = 1'b0;
        xs[nsamp] = b ? 1 : -1;
        nsamp++;
        exp_v = (nsamp >= 134) && ((nsamp - 134) % 128 == 0);
        check(valid == exp_v, (nsamp <= 134) ? "R2 strobe" : "R3 strobe", int'(valid), int'(exp_v));
        if (exp_v) begin
            e = conv_at(nsamp - 1);
            check(result == e, "R4 value", int'(result), e);
            last_res = e;
        end else begin
            check(result == last_res, "R5 hold", int'(result), last_res);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            check(!valid && result == last_res, "R7 idle", int'(result), last_res);
        end
    endtask

    task automatic do_start(bit with_en, bit b);
        start = 1'b1;
        smp_en = with_en;
        mod_bit = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        smp_en = 1'b0;
        nsamp = 0;
        last_res = 0;
        check(!valid && result == 0, "R6 start", int'(result), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_en = 1'b0;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nsamp = 0;
        last_res = 0;
        check(!valid && result == 0, "R8 reset", int'(result), 0);
    endtask

    initial begin
        build_h();
        void'($urandom(32'd24681));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!valid && result == 0, "R8 reset state", int'(result), 0);

        // R1: all ones, two results
        for (int i = 0; i < 262; i++) begin
            push(1'b1);
            if (i == 133) check(result == 2048, "R1 ones", int'(result), 2048);
        end
        check(result == 2048, "R1 ones second", int'(result), 2048);

        // R1: all zeros
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 134; i++) push(1'b0);
        check(result == -2048, "R1 zeros", int'(result), -2048);

        // R4 / R7: random bits, irregular enables
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 134 + 128 * 3; i++) begin
            push(1'($urandom % 2));
            idle(int'($urandom % 3));
        end

        // R4: alternating pattern
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 262; i++) push(1'(i % 2));

        // R6: start lands on the sample that would complete a result
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 133; i++) push(1'($urandom % 2));
        do_start(1'b1, 1'b1);
        idle(2);
        for (int i = 0; i < 134; i++) push(1'b0);
        check(result == -2048, "R6 collision dropped", int'(result), -2048);

        // R8: reset mid-conversion restarts
        for (int i = 0; i < 70; i++) push(1'($urandom % 2));
        do_reset();
        for (int i = 0; i < 134; i++) begin
            push(1'b1);
            idle(int'($urandom % 2));
        end
        check(result == 2048, "R8 restart", int'(result), 2048);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule